// File: doc/BRIEF.md
# PWM Time-Base Counter

This block is the timing core of a PWM generator. It holds a control word and a period value, which a register bus writes. A two-stage prescaler divides the input clock into update ticks. On each tick the counter moves up, down or up-and-down between zero and the active period, or it holds its value. Downstream compare and action logic reads the counter value and two strobes, each one clock wide. One strobe marks the counter arriving at zero and the other marks it arriving at the period.

A new period can go to a shadow copy, which becomes active when the counter next arrives at zero. It can also take effect at once. A halt request input lets a debug controller suspend the waveform. The run-mode field sets how that request acts: it stops the counter at the next update, stops it at the end of the current cycle, or is ignored.

Top module: `pwm_timebase`

## Requirements
- R1: While `rst_n` is low, and until the first update after reset, `cnt_out` is 0 and both strobes are low. The control word resets to 0 and the active period resets to 0.
- R2: The control field bits 12:10 (value p) and bits 9:7 (value q) set the tick ratio to 2^p × (q == 0 ? 1 : 2q). The counter updates once every ratio clocks.
- R3: Any control write restarts the prescaler. The first update under the new word comes a full ratio of clocks after the write edge.
- R4: Mode bits 1:0 = 00 counts up. When the counter is at or above the active period, the next update loads 0. Otherwise the update adds 1.
- R5: Mode 01 counts down. An update at 0 loads the active period. Otherwise the update subtracts 1.
- R6: Mode 10 counts up to the period, then down to 0, then up again. Each turning value appears once.
- R7: Mode 11 freezes the counter. No updates take place and no strobes are raised.
- R8: Run bits 15:14 = 00 with `halt_req` high blocks every update for as long as the request is held.
- R9: Run bits 15:14 = 01 with `halt_req` high lets updates continue until the counter is 0, then holds it at 0.
- R10: Run bits 15:14 = 1x ignores `halt_req`.
- R11: Control bit 3 = 0 (shadow mode): a period write goes to the shadow copy only. The shadow copy, as it stood before that edge, becomes active on the update that brings the counter to 0.
- R12: Control bit 3 = 1 (immediate mode): a period write becomes the active period at the write edge.
- R13: `zero_evt` is high for exactly the clock after an update whose new value is 0. `prd_evt` is high for exactly the clock after an update whose new value equals the active period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word data |
| prd_wr | input | 1 | Period write strobe |
| prd_wdata | input | 16 | Period write data |
| halt_req | input | 1 | Debug halt request |
| cnt_out | output | 16 | Counter value |
| zero_evt | output | 1 | Counter-arrived-at-zero strobe |
| prd_evt | output | 1 | Counter-arrived-at-period strobe |

## Verification
The bench shrinks the period below the current count in immediate mode. A design that tested for equality instead of at-or-above would run through the whole 16-bit range before it wrapped. It writes the shadow period in the middle of a cycle, in up mode and in down mode. A design that copied the shadow at once, or on the wrong boundary, would produce a cycle of the wrong length. It rewrites the control word between prescaler ticks with ratios of 8 and 6. A prescaler that failed to restart would make the first tick come early. It also toggles the halt request under all three run modes. A cycle-end stop that fired too early would freeze the counter away from zero.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;

   localparam int CTL_W        = 16;
   localparam int RUN_LSB      = 14;
   localparam int POW_LSB      = 10;
   localparam int LIN_LSB      = 7;
   localparam int LOAD_BIT     = 3;
   localparam int MODE_LSB     = 0;

   typedef enum logic [1:0] {
      CM_UP   = 2'b00,
      CM_DOWN = 2'b01,
      CM_UPDN = 2'b10,
      CM_HOLD = 2'b11
   } cnt_mode_e;

   typedef enum logic [1:0] {
      RUN_STOP_NOW   = 2'b00,
      RUN_STOP_CYCLE = 2'b01,
      RUN_FREE       = 2'b10,
      RUN_FREE_ALT   = 2'b11
   } run_mode_e;

endpackage

// File: rtl/pwm_tb_prescaler.sv
module pwm_tb_prescaler #(
   parameter int POW_W = 3,
   parameter int LIN_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [POW_W-1:0] pow_sel,
   input  logic [LIN_W-1:0] lin_sel,
   output logic             tick
);
   localparam int S1_W = 1 << POW_W;
   localparam int S2_W = LIN_W + 1;
   localparam int PW   = S1_W + S2_W;

   logic [S1_W-1:0] stage1;
   logic [S2_W-1:0] stage2;
   logic [PW-1:0]   ratio;
   logic [PW-1:0]   pcnt;

   initial begin
      assert (POW_W >= 1 && POW_W <= 4) else $error("prescaler: POW_W out of range");
      assert (LIN_W >= 1) else $error("prescaler: LIN_W out of range");
   end

   always_comb begin
      stage1 = S1_W'(1) << pow_sel;
      stage2 = (lin_sel == '0) ? S2_W'(1) : {lin_sel, 1'b0};
      ratio  = PW'(stage1) * PW'(stage2);
   end

   assign tick = (pcnt >= ratio - PW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)       pcnt <= '0;
      else if (restart) pcnt <= '0;
      else if (tick)    pcnt <= '0;
      else              pcnt <= pcnt + PW'(1);
   end

   a_r3_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (pcnt == '0));
   a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (pcnt < ratio));

endmodule

// File: rtl/pwm_tb_period.sv
module pwm_tb_period #(
   parameter int          W         = 16,
   parameter bit          SHADOW_EN = 1'b1,
   parameter logic [W-1:0] PRD_RST  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         imm,
   input  logic         load,
   output logic [W-1:0] act
);
   generate
      if (SHADOW_EN) begin : g_shadow
         logic [W-1:0] shd;

         always_ff @(posedge clk) begin
            if (!rst_n)  shd <= PRD_RST;
            else if (wr) shd <= wdata;
         end

         always_ff @(posedge clk) begin
            if (!rst_n)          act <= PRD_RST;
            else if (wr && imm)  act <= wdata;
            else if (load)       act <= shd;
         end

         a_r11_shadow_copy: assert property (@(posedge clk) disable iff (!rst_n)
            (load && !(wr && imm)) |=> (act == $past(shd)));
      end else begin : g_direct
         logic unused_sel;
         assign unused_sel = imm ^ load;

         always_ff @(posedge clk) begin
            if (!rst_n)  act <= PRD_RST;
            else if (wr) act <= wdata;
         end
      end
   endgenerate

   a_r12_immediate_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && imm) |=> (act == $past(wdata)));

endmodule

// File: rtl/pwm_tb_core.sv
module pwm_tb_core
   import pwm_tb_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  cnt_mode_e    mode,
   input  run_mode_e    run,
   input  logic         halt,
   input  logic [W-1:0] prd,
   output logic [W-1:0] cnt,
   output logic         reload,
   output logic         zero_evt,
   output logic         prd_evt
);
   localparam logic [W-1:0] ONE = W'(1);

   logic         dir_up;
   logic         dir_nxt;
   logic         hold;
   logic         upd;
   logic [W-1:0] nxt;

   initial assert (W >= 2) else $error("core: W too small");

   always_comb begin
      hold = (mode == CM_HOLD) ||
             (halt && ((run == RUN_STOP_NOW) ||
                       (run == RUN_STOP_CYCLE && cnt == '0)));
      upd  = tick && !hold;
   end

   always_comb begin
      nxt     = cnt;
      dir_nxt = 1'b1;
      unique case (mode)
         CM_UP:   nxt = (cnt >= prd) ? '0 : cnt + ONE;
         CM_DOWN: nxt = (cnt == '0) ? prd : cnt - ONE;
         CM_UPDN: begin
            if (dir_up) begin
               if (cnt >= prd) begin
                  dir_nxt = 1'b0;
                  nxt     = (cnt == '0) ? '0 : cnt - ONE;
               end else begin
                  nxt     = cnt + ONE;
               end
            end else begin
               if (cnt == '0) begin
                  nxt     = (prd == '0) ? '0 : ONE;
               end else begin
                  dir_nxt = 1'b0;
                  nxt     = cnt - ONE;
               end
            end
         end
         default: nxt = cnt;
      endcase
   end

   assign reload = upd && (nxt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt      <= '0;
         dir_up   <= 1'b1;
         zero_evt <= 1'b0;
         prd_evt  <= 1'b0;
      end else begin
         if (upd) begin
            cnt    <= nxt;
            dir_up <= dir_nxt;
         end
         zero_evt <= upd && (nxt == '0);
         prd_evt  <= upd && (nxt == prd);
      end
   end

   a_r7_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == CM_HOLD) |=> ($stable(cnt) && !zero_evt && !prd_evt));
   a_r8_halt_now: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && run == RUN_STOP_NOW) |=> $stable(cnt));
   a_r9_halt_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && run == RUN_STOP_CYCLE && cnt == '0) |=> (cnt == '0));
   a_r4_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && mode == CM_UP && cnt >= prd) |=> (cnt == '0));
   a_r13_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
      zero_evt |-> (cnt == '0));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
   import pwm_tb_pkg::*;
#(
   parameter int          CNT_W     = 16,
   parameter int          POW_W     = 3,
   parameter int          LIN_W     = 3,
   parameter bit          SHADOW_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic [CTL_W-1:0] ctl_wdata,
   input  logic             prd_wr,
   input  logic [CNT_W-1:0] prd_wdata,
   input  logic             halt_req,
   output logic [CNT_W-1:0] cnt_out,
   output logic             zero_evt,
   output logic             prd_evt
);
   localparam int POW_TOP = POW_LSB + POW_W - 1;
   localparam int LIN_TOP = LIN_LSB + LIN_W - 1;

   logic [1:0]       mode_q;
   logic [1:0]       run_q;
   logic [POW_W-1:0] pow_q;
   logic [LIN_W-1:0] lin_q;
   logic             imm_q;
   logic             tick;
   logic             reload;
   logic [CNT_W-1:0] prd_act;
   logic             unused_bits;

   initial begin
      assert (POW_TOP < RUN_LSB) else $error("timebase: divider field overlaps run field");
      assert (LIN_TOP < POW_LSB) else $error("timebase: divider fields overlap");
      assert (CNT_W >= 2) else $error("timebase: CNT_W too small");
   end

   assign unused_bits = ^{ctl_wdata[RUN_LSB-1:POW_TOP+1], ctl_wdata[LOAD_BIT-1:MODE_LSB+2],
                          ctl_wdata[LIN_LSB-1:LOAD_BIT+1], ctl_wdata[POW_LSB-1:LIN_TOP+1]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0;
         run_q  <= '0;
         pow_q  <= '0;
         lin_q  <= '0;
         imm_q  <= 1'b0;
      end else if (ctl_wr) begin
         mode_q <= ctl_wdata[MODE_LSB +: 2];
         run_q  <= ctl_wdata[RUN_LSB +: 2];
         pow_q  <= ctl_wdata[POW_LSB +: POW_W];
         lin_q  <= ctl_wdata[LIN_LSB +: LIN_W];
         imm_q  <= ctl_wdata[LOAD_BIT];
      end
   end

   pwm_tb_prescaler #(.POW_W(POW_W), .LIN_W(LIN_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (ctl_wr),
      .pow_sel (pow_q),
      .lin_sel (lin_q),
      .tick    (tick)
   );

   pwm_tb_period #(.W(CNT_W), .SHADOW_EN(SHADOW_EN), .PRD_RST('0)) u_prd (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (prd_wr),
      .wdata (prd_wdata),
      .imm   (imm_q),
      .load  (reload),
      .act   (prd_act)
   );

   pwm_tb_core #(.W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .mode     (cnt_mode_e'(mode_q)),
      .run      (run_mode_e'(run_q)),
      .halt     (halt_req),
      .prd      (prd_act),
      .cnt      (cnt_out),
      .reload   (reload),
      .zero_evt (zero_evt),
      .prd_evt  (prd_evt)
   );

   a_r10_free_ignores_halt: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q[1] && tick && mode_q == 2'b00 && cnt_out < prd_act) |=> (cnt_out == $past(cnt_out) + CNT_W'(1)));

endmodule

// File: tb/sim_pwm_timebase.sv
module sim_pwm_timebase;

   typedef struct {
      int c;
      bit z;
      bit p;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_wr = 1'b0;
   logic [15:0] ctl_wdata = '0;
   logic        prd_wr = 1'b0;
   logic [15:0] prd_wdata = '0;
   logic        halt_req = 1'b0;
   logic [15:0] cnt_out;
   logic        zero_evt;
   logic        prd_evt;

   int    checks = 0;
   int    fails = 0;
   bit    done = 1'b0;
   string cur = "R1";
   exp_t  q[$];

   // model state
   logic [15:0] m_ctl = '0;
   int m_pc = 0, m_cnt = 0, m_act = 0, m_shd = 0;
   bit m_up = 1'b1;

   always #4 clk = ~clk;

   pwm_timebase u0 (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .prd_wr(prd_wr), .prd_wdata(prd_wdata), .halt_req(halt_req),
      .cnt_out(cnt_out), .zero_evt(zero_evt), .prd_evt(prd_evt)
   );

   // driver-side model: predicts each cycle from the requirements and queues it
   always @(posedge clk) begin
      int md, rn, p2, ln, d, nx, old_shd;
      bit tk, hold, upd, nd;
      exp_t e;
      if (!rst_n) begin
         m_ctl = '0; m_pc = 0; m_cnt = 0; m_act = 0; m_shd = 0; m_up = 1'b1;
      end else begin
         md = int'(m_ctl[1:0]); rn = int'(m_ctl[15:14]);
         p2 = int'(m_ctl[12:10]); ln = int'(m_ctl[9:7]);
         d  = (1 << p2) * ((ln == 0) ? 1 : 2 * ln);
         tk = (m_pc >= d - 1);
         hold = (md == 3) || (halt_req && (rn == 0 || (rn == 1 && m_cnt == 0)));
         upd = tk && !hold;
         nx = m_cnt; nd = 1'b1;
         case (md)
            0: nx = (m_cnt >= m_act) ? 0 : m_cnt + 1;
            1: nx = (m_cnt == 0) ? m_act : m_cnt - 1;
            2: if (m_up) begin
                  if (m_cnt >= m_act) begin nd = 1'b0; nx = (m_cnt == 0) ? 0 : m_cnt - 1; end
                  else nx = m_cnt + 1;
               end else begin
                  if (m_cnt == 0) nx = (m_act == 0) ? 0 : 1;
                  else begin nd = 1'b0; nx = m_cnt - 1; end
               end
            default: nx = m_cnt;
         endcase
         e.c = upd ? nx : m_cnt;
         e.z = upd && (nx == 0);
         e.p = upd && (nx == m_act);
         q.push_back(e);
         old_shd = m_shd;
         if (prd_wr) m_shd = int'(prd_wdata);
         if (prd_wr && m_ctl[3]) m_act = int'(prd_wdata);
         else if (upd && nx == 0) m_act = old_shd;
         if (upd) begin m_cnt = nx; m_up = nd; end
         m_pc = ctl_wr ? 0 : (tk ? 0 : m_pc + 1);
         if (ctl_wr) m_ctl = ctl_wdata;
      end
   end

   // monitor: compares outputs with queued predictions away from the clock edge
   always @(negedge clk) begin
      exp_t e;
      if (rst_n && q.size() > 0) begin
         e = q.pop_front();
         checks++;
         if (int'(cnt_out) != e.c) begin
            fails++;
            $display("FAIL %s cnt actual=%0d expected=%0d", cur, cnt_out, e.c);
         end
         checks++;
         if (zero_evt != e.z || prd_evt != e.p) begin
            fails++;
            $display("FAIL R13 (%s) zero/prd actual=%b/%b expected=%b/%b",
                     cur, zero_evt, prd_evt, e.z, e.p);
         end
      end
   end

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_ctl(input logic [15:0] v);
      ctl_wdata = v; ctl_wr = 1'b1;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic wr_prd(input int v);
      prd_wdata = 16'(v); prd_wr = 1'b1;
      @(negedge clk);
      prd_wr = 1'b0;
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_up();
   end

   initial begin
      run(3);
      checks++;
      if (cnt_out !== 16'd0 || zero_evt !== 1'b0 || prd_evt !== 1'b0) begin
         fails++;
         $display("FAIL R1 reset actual=%0d/%b/%b expected=0/0/0", cnt_out, zero_evt, prd_evt);
      end
      rst_n = 1'b1;
      run(1);
      checks++;
      if (cnt_out !== 16'd0) begin
         fails++;
         $display("FAIL R1 after reset actual=%0d expected=0", cnt_out);
      end
      // R4: up counting, immediate period, ratio 1
      cur = "R4";  wr_ctl(16'hC008); wr_prd(5); run(20);
      // R12: shrink period below count in immediate mode
      cur = "R12"; run(4); wr_prd(2); run(15);
      // R2: ratio 2^1 * 2*2 = 8
      cur = "R2";  wr_ctl(16'hC008 | (16'd1 << 10) | (16'd2 << 7)); wr_prd(3); run(80);
      // R3: control rewrite between ticks restarts the prescaler
      cur = "R3";  run(3); wr_ctl(16'hC008 | (16'd1 << 10) | (16'd2 << 7)); run(20);
      run(5); wr_ctl(16'hC008 | (16'd3 << 7)); run(40);
      // R5: down counting
      cur = "R5";  wr_ctl(16'hC009); wr_prd(4); run(20);
      // R6: up-down counting, ratio 1 then ratio 2
      cur = "R6";  wr_ctl(16'hC00A); run(30);
      wr_ctl(16'hC00A | (16'd1 << 7)); run(40);
      // R7: freeze
      cur = "R7";  wr_ctl(16'hC00B); run(10); wr_ctl(16'hC008); run(6);
      // R8: stop at next update
      cur = "R8";  wr_ctl(16'h0008); wr_prd(6); run(5); halt_req = 1'b1; run(8); halt_req = 1'b0; run(5);
      // R9: stop at end of cycle
      cur = "R9";  wr_ctl(16'h4008); run(3); halt_req = 1'b1; run(15); halt_req = 1'b0; run(5);
      // R10: free run ignores halt
      cur = "R10"; wr_ctl(16'h8008); halt_req = 1'b1; run(15); halt_req = 1'b0;
      // R11: shadow load in up and down mode
      cur = "R11"; wr_ctl(16'hC000); run(2); wr_prd(9); run(30); run(3); wr_prd(3); run(30);
      wr_ctl(16'hC001); run(2); wr_prd(6); run(30);
      cur = "R13"; wr_ctl(16'hC00A); wr_prd(0); run(10);
      run(2);
      finish_up();
   end

endmodule